// File: doc/BRIEF.md
# PWM-Synchronized ADC Trigger and Current-Sense Hold Control

This block sits beside a multi-channel PWM counter. It watches the running counter value, the programmed period and the alignment mode. From these it issues single-cycle conversion-start pulses to an ADC, so that current samples line up with the switching pattern.

In edge-aligned operation there is one pulse per period. In center-aligned operation there are two pulses per period: one at the valley of the count and one at its peak.

The block also drives the control level of a current-sense sample-and-hold amplifier. The level can stay in sample permanently. It can also hold whenever any of a chosen set of high-side or low-side PWM outputs is on, or only while every chosen output is on. A small write-only register port sets the trigger enable, the hold mode and the two output-selection masks.

Top module: `pwm_adc_sync`

## Requirements
- R1: While reset is low, and after reset, both outputs are 0. The trigger is disabled, the hold mode is always-sample and both masks are 0 until they are written.
- R2: With the trigger enabled and center_mode low, adc_trig is 1 in the clock cycle after the counter arrives at the period value.
- R3: With the trigger enabled and center_mode high, adc_trig is 1 in the clock cycle after the counter arrives at zero (end of period). It is also 1 in the cycle after the counter arrives at the period value (mid-period turnaround).
- R4: With the trigger enable bit clear, adc_trig stays 0 whatever the counter does.
- R5: "Arrives" means the counter differs from its value on the previous clock; after reset that previous value counts as zero. A counter that pauses on a matching value therefore yields a single one-cycle pulse.
- R6: Hold mode is written in bits [2:1] of the control register (address 0). Codes 00 and 11 keep sh_hold at 0 (sample) regardless of the PWM outputs.
- R7: Hold-mode code 01 (any): sh_hold is 1 in the cycle after at least one masked high-side or masked low-side output is on, and 0 otherwise.
- R8: Hold-mode code 10 (all): sh_hold is 1 in the cycle after every masked output is on, provided at least one output is selected. With no output selected it is 0.
- R9: Control bit 0 at address 0 enables the trigger. Address 1 holds the high-side mask and address 2 the low-side mask (bit i selects channel i). Writes take effect at the next clock edge. Writes to address 3 change nothing, and unmasked outputs never affect sh_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW (max(NCH,3)) | Register write data |
| pwm_cnt | input | CW | Current PWM counter value |
| pwm_period | input | CW | PWM period value |
| center_mode | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| hi_on | input | NCH | On state of each high-side PWM output |
| lo_on | input | NCH | On state of each low-side PWM output |
| adc_trig | output | 1 | One-cycle ADC conversion-start pulse |
| sh_hold | output | 1 | Sample/hold control: 1 hold, 0 sample |

## Verification
The bench builds the block with CW = 8 and NCH = 4. The short counter lets many complete edge- and center-aligned periods, with randomly chosen period values including 1 and 255, run in a few thousand cycles. Four channels per side give only 256 mask pairs, so random writes cover empty masks, single-channel masks and full masks in both any and all modes. Directed cases add a counter that stalls on a matching value and writes to the unused address.

// File: rtl/pwm_adc_sync_pkg.sv
package pwm_adc_sync_pkg;

  typedef enum logic [1:0] {
    HOLD_OFF  = 2'b00,
    HOLD_ANY  = 2'b01,
    HOLD_ALL  = 2'b10,
    HOLD_RSVD = 2'b11
  } hold_mode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_HMASK = 2'd1;
  localparam logic [1:0] ADDR_LMASK = 2'd2;

endpackage

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
  import pwm_adc_sync_pkg::*;
#(
  parameter  int NCH = 4,
  localparam int DW  = (NCH > 3) ? NCH : 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic           trig_en,
  output hold_mode_e     hold_mode,
  output logic [NCH-1:0] hi_mask,
  output logic [NCH-1:0] lo_mask
);

  logic           en_d;
  hold_mode_e     mode_d;
  logic [NCH-1:0] hm_d, lm_d;
  logic           ctrl_we, hm_we, lm_we;

  assign ctrl_we = reg_wr && (reg_addr == ADDR_CTRL);
  assign hm_we   = reg_wr && (reg_addr == ADDR_HMASK);
  assign lm_we   = reg_wr && (reg_addr == ADDR_LMASK);

  always_comb begin
    en_d   = trig_en;
    mode_d = hold_mode;
    hm_d   = hi_mask;
    lm_d   = lo_mask;
    if (ctrl_we) begin
      en_d   = reg_wdata[0];
      mode_d = hold_mode_e'(reg_wdata[2:1]);
    end
    if (hm_we) hm_d = reg_wdata[NCH-1:0];
    if (lm_we) lm_d = reg_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_en   <= 1'b0;
      hold_mode <= HOLD_OFF;
      hi_mask   <= '0;
      lo_mask   <= '0;
    end else begin
      trig_en   <= en_d;
      hold_mode <= mode_d;
      hi_mask   <= hm_d;
      lo_mask   <= lm_d;
    end
  end

endmodule

// File: rtl/pwm_trig_gen.sv
module pwm_trig_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_en,
  input  logic          center_mode,
  input  logic [CW-1:0] pwm_cnt,
  input  logic [CW-1:0] pwm_period,
  output logic          adc_trig
);

  logic [CW-1:0] cnt_q;
  logic          arrived;
  logic          at_top, at_bottom;
  logic          end_hit, mid_hit;
  logic          trig_d;

  // An event counts only on the cycle the counter lands on a value.
  assign arrived   = (pwm_cnt != cnt_q);
  assign at_top    = (pwm_cnt == pwm_period);
  assign at_bottom = (pwm_cnt == '0);

  always_comb begin
    if (center_mode) begin
      end_hit = at_bottom;
      mid_hit = at_top;
    end else begin
      end_hit = at_top;
      mid_hit = 1'b0;
    end
    trig_d = trig_en && arrived && (end_hit || mid_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      adc_trig <= 1'b0;
    end else begin
      cnt_q    <= pwm_cnt;
      adc_trig <= trig_d;
    end
  end

endmodule

// File: rtl/pwm_hold_ctl.sv
module pwm_hold_ctl
  import pwm_adc_sync_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  hold_mode_e     hold_mode,
  input  logic [NCH-1:0] hi_on,
  input  logic [NCH-1:0] lo_on,
  input  logic [NCH-1:0] hi_mask,
  input  logic [NCH-1:0] lo_mask,
  output logic           sh_hold
);

  logic [NCH-1:0] hi_sat, lo_sat;
  logic           any_on, all_on, any_sel;
  logic           hold_d;

  // Per channel: an unselected output always counts as satisfied for "all".
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hi_sat[i] = hi_on[i] || !hi_mask[i];
    assign lo_sat[i] = lo_on[i] || !lo_mask[i];
  end

  assign any_on  = |(hi_on & hi_mask) || |(lo_on & lo_mask);
  assign any_sel = |hi_mask || |lo_mask;
  assign all_on  = (&hi_sat) && (&lo_sat) && any_sel;

  always_comb begin
    unique case (hold_mode)
      HOLD_ANY: hold_d = any_on;
      HOLD_ALL: hold_d = all_on;
      default:  hold_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_hold <= 1'b0;
    else        sh_hold <= hold_d;
  end

endmodule

// File: rtl/pwm_adc_sync.sv
module pwm_adc_sync
  import pwm_adc_sync_pkg::*;
#(
  parameter  int CW  = 16,
  parameter  int NCH = 4,
  localparam int DW  = (NCH > 3) ? NCH : 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [1:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic [CW-1:0]  pwm_cnt,
  input  logic [CW-1:0]  pwm_period,
  input  logic           center_mode,
  input  logic [NCH-1:0] hi_on,
  input  logic [NCH-1:0] lo_on,
  output logic           adc_trig,
  output logic           sh_hold
);

  logic           trig_en;
  hold_mode_e     hold_mode;
  logic [NCH-1:0] hi_mask, lo_mask;

  pwm_sync_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .trig_en   (trig_en),
    .hold_mode (hold_mode),
    .hi_mask   (hi_mask),
    .lo_mask   (lo_mask)
  );

  pwm_trig_gen #(.CW(CW)) u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_en     (trig_en),
    .center_mode (center_mode),
    .pwm_cnt     (pwm_cnt),
    .pwm_period  (pwm_period),
    .adc_trig    (adc_trig)
  );

  pwm_hold_ctl #(.NCH(NCH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_mode (hold_mode),
    .hi_on     (hi_on),
    .lo_on     (lo_on),
    .hi_mask   (hi_mask),
    .lo_mask   (lo_mask),
    .sh_hold   (sh_hold)
  );

endmodule

// File: rtl/pwm_adc_sync_chk.sv
module pwm_adc_sync_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  pwm_cnt,
  input logic [CW-1:0]  pwm_period,
  input logic           center_mode,
  input logic [NCH-1:0] hi_on,
  input logic [NCH-1:0] lo_on,
  input logic [NCH-1:0] hi_mask,
  input logic [NCH-1:0] lo_mask,
  input logic           trig_en,
  input logic [1:0]     hold_mode,
  input logic           adc_trig,
  input logic           sh_hold
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!adc_trig && !sh_hold));

  // R2
  edge_end_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && trig_en && !center_mode && pwm_cnt == pwm_period && pwm_cnt != $past(pwm_cnt))
    |=> adc_trig);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> !adc_trig);

  // R5
  stall_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && pwm_cnt == $past(pwm_cnt)) |=> !adc_trig);

  // R6
  sample_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode == 2'b00 || hold_mode == 2'b11) |=> !sh_hold);

  // R7
  any_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode == 2'b01 && ((hi_on & hi_mask) != '0 || (lo_on & lo_mask) != '0)) |=> sh_hold);

  // R8
  all_empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode == 2'b10 && hi_mask == '0 && lo_mask == '0) |=> !sh_hold);

endmodule

bind pwm_adc_sync pwm_adc_sync_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_cnt     (pwm_cnt),
  .pwm_period  (pwm_period),
  .center_mode (center_mode),
  .hi_on       (hi_on),
  .lo_on       (lo_on),
  .hi_mask     (hi_mask),
  .lo_mask     (lo_mask),
  .trig_en     (trig_en),
  .hold_mode   (hold_mode),
  .adc_trig    (adc_trig),
  .sh_hold     (sh_hold)
);

// File: tb/tb_pwm_adc_sync.sv
module tb_pwm_adc_sync;

  localparam int CW  = 8;
  localparam int NCH = 4;
  localparam int DW  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           reg_wr;
  logic [1:0]     reg_addr;
  logic [DW-1:0]  reg_wdata;
  logic [CW-1:0]  pwm_cnt, pwm_period;
  logic           center_mode;
  logic [NCH-1:0] hi_on, lo_on;
  logic           adc_trig, sh_hold;

  always #10 clk = ~clk;

  pwm_adc_sync #(.CW(CW), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pwm_cnt(pwm_cnt), .pwm_period(pwm_period),
    .center_mode(center_mode), .hi_on(hi_on), .lo_on(lo_on),
    .adc_trig(adc_trig), .sh_hold(sh_hold)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic           m_en;
  logic [1:0]     m_mode;
  logic [NCH-1:0] m_hm, m_lm;
  logic [CW-1:0]  m_prev;
  logic [CW-1:0]  g_period;
  logic           g_center;
  string          g_tag;

  logic  exp_t, exp_h;
  string tag_t, tag_h;

  function automatic logic f_trig(logic en, logic ctr, logic [CW-1:0] c,
                                  logic [CW-1:0] pv, logic [CW-1:0] p);
    logic hit;
    hit = ctr ? (c == '0 || c == p) : (c == p);
    return en && (c != pv) && hit;
  endfunction

  function automatic logic f_hold(logic [1:0] md, logic [NCH-1:0] hm, logic [NCH-1:0] lm,
                                  logic [NCH-1:0] hi, logic [NCH-1:0] lo);
    case (md)
      2'b01:   return ((hi & hm) != '0) || ((lo & lm) != '0);
      2'b10:   return ((hm | lm) != '0) && ((hi & hm) == hm) && ((lo & lm) == lm);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic got, logic expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, expv, $time);
    end
  endtask

  // One clock: check previous expectation, drive new inputs, predict.
  task automatic step(logic [CW-1:0] c, logic [NCH-1:0] hi, logic [NCH-1:0] lo,
                      logic wr, logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    chk(tag_t, "adc_trig", adc_trig, exp_t);
    chk(tag_h, "sh_hold", sh_hold, exp_h);
    pwm_cnt     = c;
    pwm_period  = g_period;
    center_mode = g_center;
    hi_on       = hi;
    lo_on       = lo;
    reg_wr      = wr;
    reg_addr    = a;
    reg_wdata   = d;
    exp_t = f_trig(m_en, g_center, c, m_prev, g_period);
    exp_h = f_hold(m_mode, m_hm, m_lm, hi, lo);
    if (g_tag != "") begin
      tag_t = g_tag; tag_h = g_tag;
    end else begin
      tag_t = !m_en ? "R4" : (g_center ? "R3" : "R2");
      tag_h = (m_mode == 2'b01) ? "R7" : (m_mode == 2'b10) ? "R8" : "R6";
    end
    m_prev = c;
    if (wr) begin
      case (a)
        2'd0: begin m_en = d[0]; m_mode = d[2:1]; end
        2'd1: m_hm = d[NCH-1:0];
        2'd2: m_lm = d[NCH-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [DW-1:0] d);
    step(m_prev, hi_on, lo_on, 1'b1, a, d);
  endtask

  // One full PWM period with random outputs and occasional random writes.
  task automatic run_period(bit rnd_wr);
    int n;
    n = g_center ? 2 * int'(g_period) : int'(g_period) + 1;
    for (int k = 0; k < n; k++) begin
      logic [CW-1:0] c;
      logic w;
      if (!g_center)            c = CW'(k);
      else if (k <= g_period)   c = CW'(k);
      else                      c = CW'(2 * int'(g_period) - k);
      w = rnd_wr && ($urandom_range(0, 9) == 0);
      step(c, NCH'($urandom), NCH'($urandom), w, 2'($urandom), DW'($urandom));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pwm_cnt = '0; pwm_period = 8'd10; center_mode = 1'b0; hi_on = '1; lo_on = '1;
    m_en = 0; m_mode = 2'b00; m_hm = '0; m_lm = '0; m_prev = '0;
    g_period = 8'd10; g_center = 1'b0; g_tag = "R1";
    exp_t = 0; exp_h = 0; tag_t = "R1"; tag_h = "R1";

    // R1: outputs low during reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1", "adc_trig in reset", adc_trig, 1'b0);
      chk("R1", "sh_hold in reset", sh_hold, 1'b0);
    end
    rst_n = 1'b1;

    // R1: defaults leave trigger off and hold in sample, even with masks set
    wr_reg(2'd1, '1);
    wr_reg(2'd2, '1);
    for (int k = 0; k <= 10; k++) step(CW'(k), '1, '1, 1'b0, '0, '0);

    // R4: trigger disabled, random center/edge periods
    g_tag = "";
    for (int p = 0; p < 6; p++) begin
      g_period = CW'($urandom_range(1, 30)); g_center = 1'($urandom);
      run_period(1'b0);
    end

    // R2: edge-aligned periods, including the extremes of the period
    wr_reg(2'd0, 4'b0001);
    g_center = 1'b0;
    g_period = 8'd1;   run_period(1'b0);
    g_period = 8'd255; run_period(1'b0);
    for (int p = 0; p < 10; p++) begin
      g_period = CW'($urandom_range(2, 40)); run_period(1'b0);
    end

    // R3: center-aligned periods
    g_center = 1'b1;
    g_period = 8'd1;   run_period(1'b0);
    g_period = 8'd255; run_period(1'b0);
    for (int p = 0; p < 10; p++) begin
      g_period = CW'($urandom_range(2, 40)); run_period(1'b0);
    end

    // R5: counter stalls on the period value and on zero
    g_tag = "R5"; g_center = 1'b0; g_period = 8'd6;
    for (int k = 0; k <= 6; k++) step(CW'(k), '0, '0, 1'b0, '0, '0);
    for (int k = 0; k < 5; k++)  step(8'd6, '0, '0, 1'b0, '0, '0);
    g_center = 1'b1;
    for (int k = 5; k >= 0; k--) step(CW'(k), '0, '0, 1'b0, '0, '0);
    for (int k = 0; k < 5; k++)  step(8'd0, '0, '0, 1'b0, '0, '0);
    g_tag = "";

    // R6 R7 R8: hold modes with random masks and random writes
    for (int md = 0; md < 4; md++) begin
      wr_reg(2'd0, DW'({md[1:0], 1'b1}));
      for (int p = 0; p < 8; p++) begin
        wr_reg(2'd1, DW'($urandom));
        wr_reg(2'd2, DW'($urandom));
        g_period = CW'($urandom_range(3, 25)); g_center = 1'($urandom);
        run_period(1'b0);
      end
    end

    // R8: empty selection in all mode, and a single selected channel
    wr_reg(2'd0, 4'b0101);
    wr_reg(2'd1, '0); wr_reg(2'd2, '0);
    for (int k = 0; k < 8; k++) step(CW'(k), '1, '1, 1'b0, '0, '0);
    wr_reg(2'd2, 4'b0100);
    for (int k = 0; k < 16; k++) step(CW'(k), '0, NCH'(k), 1'b0, '0, '0);

    // R9: address 3 writes change nothing; unmasked outputs ignored
    g_tag = "R9";
    wr_reg(2'd0, 4'b0011);
    wr_reg(2'd1, 4'b0010); wr_reg(2'd2, 4'b0000);
    wr_reg(2'd3, 4'b1111);
    for (int k = 0; k < 16; k++) step(CW'(k), NCH'(k) & 4'b1101, '1, 1'b0, '0, '0);
    step(8'd3, 4'b0010, '0, 1'b0, '0, '0);
    g_period = 8'd5; g_center = 1'b0;
    for (int k = 0; k < 6; k++) step(CW'(k), '0, '0, 1'b1, 2'd3, '1);
    g_tag = "";

    // mixed random traffic
    for (int p = 0; p < 40; p++) begin
      g_period = CW'($urandom_range(1, 20)); g_center = 1'($urandom);
      run_period(1'b1);
    end

    step(8'd0, '0, '0, 1'b0, '0, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule